// File: doc/BRIEF.md
# Sync-First Raster Timing Generator

This block produces the horizontal and vertical sync pulses for a 640x480 raster at about 60 Hz. It is driven by a system clock and a pixel-rate clock enable. Each line and each frame begins with its sync pulse, and active video follows later in the period. A horizontal counter counts pixel enables. A vertical counter steps once each time the horizontal counter wraps.

The block also gives a pixel engine what it needs. It drives the current line number, so a scanout unit can decide blanking for itself. It also raises a one-cycle scanout request when the horizontal count reaches a fixed position in every line. A run input holds the whole generator idle: both counters sit at zero and both syncs are deasserted. When run rises again, counting restarts from the top of a frame.

All timing values are parameters. The defaults give 800 pixels per line with a 64-pixel sync, 497 lines per frame with a 3-line sync, and a scanout trigger at pixel 90. At a 23.856 MHz pixel rate this gives a line rate near 29.82 kHz and a frame rate of 60.00 Hz.

Top module: `sync_first_vga_timer`

## Requirements
- R1: While run was low at the last clock edge, hsync_n and vsync_n are 1, line_num is 0 and scan_req is 0.
- R2: Within a line, hsync_n is 0 (active low) exactly while the horizontal count is below H_SYNC_END - H_SYNC_START, and 1 for the rest of the line.
- R3: The horizontal count advances by one on each clock edge where run and pix_en are high. After H_TOTAL - 1 it wraps to 0, so every line lasts H_TOTAL pixel enables and starts with hsync_n at 0.
- R4: line_num is the vertical count. It advances by one only on the pixel enable that wraps the horizontal count.
- R5: vsync_n is 0 (active low) exactly while line_num is below V_SYNC_END - V_SYNC_START.
- R6: line_num wraps from V_TOTAL - 1 to 0, so a frame lasts V_TOTAL lines and starts with vsync_n at 0.
- R7: scan_req is 1 for exactly one clock per line: the cycle where pix_en is 1 and the horizontal count equals SCAN_POS.
- R8: On a clock edge with pix_en low, the counters hold, so line_num, hsync_n and vsync_n keep their values.
- R9: After run has been low, the first cycle with run high again starts at line 0, pixel 0, with both syncs asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run | input | 1 | Generator enable; low holds idle |
| pix_en | input | 1 | Pixel-rate clock enable |
| hsync_n | output | 1 | Horizontal sync, active low |
| vsync_n | output | 1 | Vertical sync, active low |
| line_num | output | CW | Current vertical count |
| scan_req | output | 1 | One-cycle scanout request per line |

## Verification
The bench uses a shrunken raster: 20 pixels per line, 12 lines per frame. This lets it sweep several complete frames under dense, sparse and irregular pixel-enable patterns. It checks each output every cycle against an arithmetic model. The sweeps target several specific faults:
- A count that wraps at H_TOTAL instead of H_TOTAL - 1 would stretch every line and shift the sync edges.
- A vertical counter stepped by the wrong condition would drift line_num away from the line count.
- A sync comparison off by one would widen or narrow a pulse by one pixel or one line.
- A scanout request not gated by pix_en would repeat for as long as the count sits at the trigger position.
- A run input that does not fully clear the counters would resume mid-frame after a pause.

// File: rtl/vga_tg_pkg.sv
package vga_tg_pkg;

    // Default raster timing (pixels / lines)
    localparam int DEF_CW           = 10;
    localparam int DEF_H_ACTIVE     = 640;
    localparam int DEF_H_SYNC_START = 656;
    localparam int DEF_H_SYNC_END   = 720;
    localparam int DEF_H_TOTAL      = 800;
    localparam int DEF_V_ACTIVE     = 480;
    localparam int DEF_V_SYNC_START = 481;
    localparam int DEF_V_SYNC_END   = 484;
    localparam int DEF_V_TOTAL      = 497;
    localparam int DEF_SCAN_POS     = 90;

    typedef struct packed {
        logic run;
    } top_state_t;

endpackage

// File: rtl/vga_axis_counter.sv
module vga_axis_counter #(
    parameter int CW     = 10,
    parameter int TOTAL  = 800,
    parameter int SYNC_W = 64
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          step,
    output logic [CW-1:0] cnt,
    output logic          wrap,
    output logic          in_sync
);
    localparam logic [CW-1:0] LAST  = CW'(TOTAL - 1);
    localparam logic [CW-1:0] SYN_W = CW'(SYNC_W);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } axis_state_t;

    axis_state_t st_d, st_q;
    logic        at_last;

    always_comb begin
        st_d    = st_q;
        at_last = (st_q.cnt == LAST);
        if (clr) begin
            st_d.cnt = '0;
        end else if (step) begin
            st_d.cnt = at_last ? '0 : st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt     = st_q.cnt;
    assign wrap    = step && !clr && at_last;
    assign in_sync = (st_q.cnt < SYN_W);

endmodule

// File: rtl/sync_first_vga_timer.sv
module sync_first_vga_timer
    import vga_tg_pkg::*;
#(
    parameter int CW           = DEF_CW,
    parameter int H_ACTIVE     = DEF_H_ACTIVE,
    parameter int H_SYNC_START = DEF_H_SYNC_START,
    parameter int H_SYNC_END   = DEF_H_SYNC_END,
    parameter int H_TOTAL      = DEF_H_TOTAL,
    parameter int V_ACTIVE     = DEF_V_ACTIVE,
    parameter int V_SYNC_START = DEF_V_SYNC_START,
    parameter int V_SYNC_END   = DEF_V_SYNC_END,
    parameter int V_TOTAL      = DEF_V_TOTAL,
    parameter int SCAN_POS     = DEF_SCAN_POS
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic          pix_en,
    output logic          hsync_n,
    output logic          vsync_n,
    output logic [CW-1:0] line_num,
    output logic          scan_req
);
    localparam int            H_SW   = H_SYNC_END - H_SYNC_START;
    localparam int            V_SW   = V_SYNC_END - V_SYNC_START;
    localparam logic [CW-1:0] SCAN_C = CW'(SCAN_POS);

    top_state_t    top_d, top_q;
    logic          h_step, h_wrap, h_sync, v_wrap, v_sync;
    logic [CW-1:0] hcnt_w, vcnt_w;

    always_comb begin
        top_d     = top_q;
        top_d.run = run;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) top_q <= '0;
        else        top_q <= top_d;
    end

    assign h_step = run && top_q.run && pix_en;

    vga_axis_counter #(.CW(CW), .TOTAL(H_TOTAL), .SYNC_W(H_SW)) i_hcnt (
        .clk(clk), .rst_n(rst_n), .clr(!run), .step(h_step),
        .cnt(hcnt_w), .wrap(h_wrap), .in_sync(h_sync)
    );

    vga_axis_counter #(.CW(CW), .TOTAL(V_TOTAL), .SYNC_W(V_SW)) i_vcnt (
        .clk(clk), .rst_n(rst_n), .clr(!run), .step(h_wrap),
        .cnt(vcnt_w), .wrap(v_wrap), .in_sync(v_sync)
    );

    assign hsync_n  = !(top_q.run && h_sync);
    assign vsync_n  = !(top_q.run && v_sync);
    assign line_num = vcnt_w;
    assign scan_req = top_q.run && pix_en && (hcnt_w == SCAN_C);

endmodule

// File: rtl/sync_first_vga_timer_chk.sv
module sync_first_vga_timer_chk #(
    parameter int CW      = 10,
    parameter int H_TOTAL = 800,
    parameter int V_TOTAL = 497
) (
    input logic          clk,
    input logic          rst_n,
    input logic          run,
    input logic          pix_en,
    input logic          run_q,
    input logic [CW-1:0] hcnt,
    input logic          hsync_n,
    input logic          vsync_n,
    input logic [CW-1:0] line_num,
    input logic          scan_req
);
    localparam logic [CW-1:0] H_LAST = CW'(H_TOTAL - 1);

    assert_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (hsync_n && vsync_n && line_num == '0 && !scan_req));

    assert_hsync_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(hsync_n) |-> hcnt == '0);

    assert_hwrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (run && run_q && pix_en && hcnt == H_LAST) |=> hcnt == '0);

    assert_vhold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (run && run_q && pix_en && hcnt != H_LAST) |=> $stable(line_num));

    assert_vsync_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(vsync_n) |-> line_num == '0);

    assert_scan_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
        scan_req |-> pix_en);

    assert_scan_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        scan_req |=> !scan_req);

    assert_freeze_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (run && run_q && !pix_en) |=>
            ($stable(line_num) && $stable(hsync_n) && $stable(vsync_n)));

endmodule

bind sync_first_vga_timer sync_first_vga_timer_chk #(
    .CW(CW), .H_TOTAL(H_TOTAL), .V_TOTAL(V_TOTAL)
) i_chk (
    .clk(clk), .rst_n(rst_n), .run(run), .pix_en(pix_en),
    .run_q(top_q.run), .hcnt(hcnt_w), .hsync_n(hsync_n),
    .vsync_n(vsync_n), .line_num(line_num), .scan_req(scan_req)
);

// File: tb/test_sync_first_vga_timer.sv
`timescale 1ns/1ps
module test_sync_first_vga_timer;
    localparam int CW  = 10;
    localparam int HT  = 20, HSS = 14, HSE = 17;
    localparam int VT  = 12, VSS = 7,  VSE = 9;
    localparam int SP  = 9;
    localparam int HSW = HSE - HSS;
    localparam int VSW = VSE - VSS;

    logic          clk = 0, rst_n = 0, run = 0, pix_en = 0;
    logic          hsync_n, vsync_n, scan_req;
    logic [CW-1:0] line_num;

    int n_chk = 0, n_bad = 0;
    bit done = 0;
    int mh = 0, mv = 0;
    bit mrun = 0, ever_ran = 0;
    bit fresh_line = 0, fresh_frame = 0, restart = 0, held = 0;

    always #2.5 clk = ~clk;

    sync_first_vga_timer #(
        .CW(CW), .H_ACTIVE(12), .H_SYNC_START(HSS), .H_SYNC_END(HSE), .H_TOTAL(HT),
        .V_ACTIVE(6), .V_SYNC_START(VSS), .V_SYNC_END(VSE), .V_TOTAL(VT), .SCAN_POS(SP)
    ) i_sync_first_vga_timer (
        .clk(clk), .rst_n(rst_n), .run(run), .pix_en(pix_en),
        .hsync_n(hsync_n), .vsync_n(vsync_n), .line_num(line_num), .scan_req(scan_req)
    );

    task automatic chk(input string tag, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d (h=%0d v=%0d)", tag, what, act, exp, mh, mv);
        end
    endtask

    task automatic step(input bit r, input bit p);
        @(negedge clk);
        run = r; pix_en = p;
        #1;
        chk(!mrun ? "R1" : (restart ? "R9" : (fresh_line ? "R3" : "R2")), "hsync_n",
            int'(hsync_n), int'(!(mrun && mh < HSW)));
        chk(!mrun ? "R1" : (fresh_frame ? "R6" : "R5"), "vsync_n",
            int'(vsync_n), int'(!(mrun && mv < VSW)));
        chk(!mrun ? "R1" : (held ? "R8" : "R4"), "line_num", int'(line_num), mv);
        chk(!mrun ? "R1" : "R7", "scan_req", int'(scan_req), int'(mrun && p && mh == SP));
        fresh_line = 0; fresh_frame = 0; held = 0;
        if (!r) begin
            mh = 0; mv = 0; mrun = 0; restart = 0;
        end else begin
            if (mrun) begin
                restart = 0;
                if (p) begin
                    if (mh == HT - 1) begin
                        mh = 0; fresh_line = 1;
                        if (mv == VT - 1) begin mv = 0; fresh_frame = 1; end
                        else mv++;
                    end else mh++;
                end else held = 1;
            end else begin
                restart = ever_ran;
                ever_ran = 1;
            end
            mrun = 1;
        end
    endtask

    task automatic finish_up();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 5);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_up();
    end

    initial begin
        logic [7:0] lfsr = 8'hA5;
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1: idle while run low, pix_en toggling
        for (int i = 0; i < 6; i++) step(0, i[0]);
        // Dense pixel enables, more than two frames (R2..R7)
        for (int i = 0; i < 2 * HT * VT + 37; i++) step(1, 1);
        // Sparse enables, one in three (R8)
        for (int i = 0; i < 3 * HT * VT / 2; i++) step(1, (i % 3) == 0);
        // Pause mid-frame then resume (R1, R9)
        for (int i = 0; i < 4; i++) step(0, 1);
        // Irregular enables from an LFSR
        for (int i = 0; i < 3 * HT * VT; i++) begin
            step(1, lfsr[0] | lfsr[3]);
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        end
        // Second pause with run dropping on a line wrap, then dense again (R9)
        for (int i = 0; i < 2; i++) step(0, 0);
        for (int i = 0; i < HT * VT + 5; i++) step(1, 1);
        finish_up();
    end
endmodule